// File: doc/BRIEF.md
# Power-Down Entry and Wake-Up Controller

This block is the power-management register unit of a small microcontroller core. It watches the core's special-function-register write port and the instruction-boundary strobe. It raises a clock-stop output when software has written a deliberate two-step unlock sequence to the power-control register. The first write sets only the arm bit. The write on the very next instruction sets only the start bit. Both bits clear themselves and always read back as zero. The arm state lives in a hidden flag that any other instruction or write discards.

A wake configuration register chooses whether power-down may be left by an event and which source counts. The source is either a low level on an external interrupt pin, which is synchronised through two flops and gated by that pin's port latch, or a bus-activity detector. This register sits behind a map-select bit in a separate system register. While the select bit is clear, writes to it are dropped and reads of it return zero. With wake disabled, only reset leaves power-down. Register writes are ignored while the core is stopped.

Top module: `pwrdn_ctrl`

## Requirements
- R1: Power-down starts only when a write to the power register (bit 1 = arm set, bit 6 = start clear) is followed, on the next instruction, by a write with bit 6 set and bit 1 clear. clk_stop goes high at the edge that takes the start write.
- R2: A single write with bits 1 and 6 both set never starts power-down.
- R3: Bits 1 and 6 of the power register always read as 0. Its other six bits read back as last written.
- R4: The hidden arm flag is dropped at any instruction boundary, or on any register write, that is not the arm write itself. A start write with no arm write directly before it has no effect.
- R5: With wake-enable (wake register bit 7) at 0, neither the pin nor bus activity ends power-down. Only reset does.
- R6: The wake register is written and read only while the map-select bit (system register bit 4) is 1. Otherwise writes to it are dropped and its address reads 0.
- R7: With bit 7 = 1 and bit 4 = 0 in the wake register, a low level on wake_pin (with port latch 1) clears clk_stop at the third rising edge after the pin falls.
- R8: If the pin's port latch is 0 while pin wake is enabled, clk_stop is high for exactly one cycle after entry.
- R9: With wake register bits 7 and 4 both set, bus_active high during power-down clears clk_stop at the next edge, and the pin level is ignored.
- R10: Register writes presented while clk_stop is high change no register.
- R11: Reset clears clk_stop, the arm flag and all three registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | One-cycle strobe at each instruction boundary |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | AW | Write address |
| sfr_wdata | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wake_pin | input | 1 | Asynchronous external interrupt pin, low = wake |
| port_latch | input | 1 | Port latch bit of the interrupt pin |
| bus_active | input | 1 | Synchronous bus-activity indication |
| clk_stop | output | 1 | High while powered down |

## Verification
Writes and sequence steps take effect one edge after they are presented, so clk_stop reflects a start write at the first edge. Bus wake clears it one edge later. Pin wake needs three edges because of the synchroniser. The bench drives every input on the falling edge. A behavioural reference model advances on each rising edge, and model and design are compared at the next falling edge. Directed checks sample clk_stop at exactly those edge counts and also one edge early, so a wrong latency shows up as a mismatch.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // true when bit 'on_b' is set and bit 'off_b' is clear
  function automatic logic only_bit(input byte_t d, input int unsigned on_b,
                                    input int unsigned off_b);
    return d[on_b] & ~d[off_b];
  endfunction

  // mask that removes the two self-clearing bits
  function automatic byte_t clear_mask(input int unsigned a, input int unsigned b);
    byte_t m;
    m = '1;
    m[a] = 1'b0;
    m[b] = 1'b0;
    return m;
  endfunction

  // pin wake: enabled, pin source, effective pin level low
  function automatic logic pin_wake_req(input logic en, input logic src_bus,
                                        input logic pin_lvl, input logic latch);
    return en & ~src_bus & ~(pin_lvl & latch);
  endfunction

  function automatic logic bus_wake_req(input logic en, input logic src_bus,
                                        input logic act);
    return en & src_bus & act;
  endfunction
endpackage

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int unsigned ARM_BIT   = 1,
  parameter int unsigned START_BIT = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  insn_done,
  input  logic  wr_any,
  input  logic  wr_pwr,
  input  byte_t wdata,
  input  logic  wake_hit,
  output logic  arm_q,
  output logic  pd_q,
  output logic  start_hit
);
  logic arm_write;

  assign arm_write = wr_pwr & insn_done & only_bit(wdata, ARM_BIT, START_BIT);
  assign start_hit = wr_pwr & insn_done & arm_q & only_bit(wdata, START_BIT, ARM_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (arm_write) begin
      arm_q <= 1'b1;
    end else if (insn_done || wr_any) begin
      arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else if (pd_q && wake_hit) begin
      pd_q <= 1'b0;
    end else if (start_hit) begin
      pd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter logic [AW-1:0] ADDR_PWR  = 8'h87,
  parameter logic [AW-1:0] ADDR_MAP  = 8'hB1,
  parameter logic [AW-1:0] ADDR_WAKE = 8'hDD,
  parameter int unsigned ARM_BIT   = 1,
  parameter int unsigned START_BIT = 6,
  parameter int unsigned MAP_BIT   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_data,
  output byte_t         wake_q,
  output logic          map_sel
);
  localparam byte_t KEEP = clear_mask(ARM_BIT, START_BIT);

  byte_t pwr_q, map_q;

  assign map_sel = map_q[MAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      map_q  <= '0;
      wake_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_PWR)  pwr_q <= wdata & KEEP;
      if (addr == ADDR_MAP)  map_q <= wdata;
      if (addr == ADDR_WAKE && map_sel) wake_q <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_PWR)                   rd_data = pwr_q & KEEP;
    else if (rd_addr == ADDR_MAP)              rd_data = map_q;
    else if (rd_addr == ADDR_WAKE && map_sel)  rd_data = wake_q;
  end
endmodule

// File: rtl/pwrdn_wake.sv
module pwrdn_wake
  import pwrdn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic port_latch,
  input  logic bus_active,
  input  logic wake_en,
  input  logic src_bus,
  input  logic pd_q,
  output logic wake_hit
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= pin_async;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign wake_hit = pd_q & (pin_wake_req(wake_en, src_bus, sync_q[LAST], port_latch)
                          | bus_wake_req(wake_en, src_bus, bus_active));
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter logic [AW-1:0] ADDR_PWR  = 8'h87,
  parameter logic [AW-1:0] ADDR_MAP  = 8'hB1,
  parameter logic [AW-1:0] ADDR_WAKE = 8'hDD,
  parameter int unsigned ARM_BIT     = 1,
  parameter int unsigned START_BIT   = 6,
  parameter int unsigned MAP_BIT     = 4,
  parameter int unsigned WEN_BIT     = 7,
  parameter int unsigned WSRC_BIT    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          sfr_wr,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wake_pin,
  input  logic          port_latch,
  input  logic          bus_active,
  output logic          clk_stop
);
  logic  wr_live, wr_pwr, arm_q, pd_q, start_hit, wake_hit, map_sel;
  logic  wake_en, src_bus;
  byte_t wake_q;

  assign wr_live  = sfr_wr & ~pd_q;
  assign wr_pwr   = wr_live & (sfr_addr == ADDR_PWR);
  assign wake_en  = wake_q[WEN_BIT];
  assign src_bus  = wake_q[WSRC_BIT];
  assign clk_stop = pd_q;

  pwrdn_seq #(.ARM_BIT(ARM_BIT), .START_BIT(START_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .wr_any(wr_live),
    .wr_pwr(wr_pwr), .wdata(sfr_wdata), .wake_hit(wake_hit),
    .arm_q(arm_q), .pd_q(pd_q), .start_hit(start_hit)
  );

  pwrdn_regs #(.AW(AW), .ADDR_PWR(ADDR_PWR), .ADDR_MAP(ADDR_MAP),
               .ADDR_WAKE(ADDR_WAKE), .ARM_BIT(ARM_BIT),
               .START_BIT(START_BIT), .MAP_BIT(MAP_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_live), .addr(sfr_addr),
    .wdata(sfr_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_q(wake_q), .map_sel(map_sel)
  );

  pwrdn_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin_async(wake_pin), .port_latch(port_latch),
    .bus_active(bus_active), .wake_en(wake_en), .src_bus(src_bus),
    .pd_q(pd_q), .wake_hit(wake_hit)
  );
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int unsigned AW          = 8,
  parameter logic [AW-1:0] ADDR_PWR  = 8'h87,
  parameter logic [AW-1:0] ADDR_WAKE = 8'hDD,
  parameter int unsigned ARM_BIT     = 1,
  parameter int unsigned START_BIT   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_done,
  input logic          sfr_wr,
  input logic [AW-1:0] sfr_addr,
  input logic [7:0]    sfr_wdata,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          bus_active,
  input logic          clk_stop,
  input logic          arm_q,
  input logic          start_hit,
  input logic          wake_hit,
  input logic          wake_en,
  input logic          src_bus,
  input logic          map_sel,
  input logic [7:0]    wake_q
);
  // R1
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> clk_stop);
  // R1
  no_stray_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stop && !start_hit) |=> !clk_stop);
  // R2
  both_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stop && sfr_wr && insn_done && sfr_addr == ADDR_PWR &&
     sfr_wdata[ARM_BIT] && sfr_wdata[START_BIT]) |=> !clk_stop);
  // R3
  selfclr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_PWR) |-> (rd_data[ARM_BIT] == 1'b0 && rd_data[START_BIT] == 1'b0));
  // R4
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((insn_done || sfr_wr) && !(sfr_wr && sfr_addr == ADDR_PWR &&
      sfr_wdata[ARM_BIT] && !sfr_wdata[START_BIT] && !clk_stop)) |=> !arm_q);
  // R5
  no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && !wake_en) |=> clk_stop);
  // R6
  map_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == ADDR_WAKE && !map_sel) |=> $stable(wake_q));
  // R9
  bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && wake_en && src_bus && bus_active) |=> !clk_stop);
  // R7
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && wake_hit) |=> !clk_stop);
  // R10
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && sfr_wr) |=> $stable(wake_q));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(
  .AW(AW), .ADDR_PWR(ADDR_PWR), .ADDR_WAKE(ADDR_WAKE),
  .ARM_BIT(ARM_BIT), .START_BIT(START_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .sfr_wr(sfr_wr),
  .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .rd_addr(rd_addr),
  .rd_data(rd_data), .bus_active(bus_active), .clk_stop(clk_stop),
  .arm_q(arm_q), .start_hit(start_hit), .wake_hit(wake_hit),
  .wake_en(wake_en), .src_bus(src_bus), .map_sel(map_sel), .wake_q(wake_q)
);

// File: tb/pwrdn_ctrl_test.sv
module pwrdn_ctrl_test;
  localparam logic [7:0] A_PWR = 8'h87, A_MAP = 8'hB1, A_WAKE = 8'hDD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_done = 0, sfr_wr = 0, wake_pin = 1, port_latch = 1, bus_active = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, rd_addr = 0, rd_data;
  logic clk_stop;

  int checks = 0, fails = 0;
  bit done = 0, model_live = 0;

  always #2 clk = ~clk;

  pwrdn_ctrl uut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .wake_pin(wake_pin), .port_latch(port_latch),
    .bus_active(bus_active), .clk_stop(clk_stop)
  );

  // behavioural reference model
  bit m_arm, m_pd, s1 = 1, s2 = 1;
  logic [7:0] m_pwr, m_map, m_wake;

  always @(posedge clk) begin
    bit wk, act, st, armw;
    logic [7:0] old_map;
    if (!rst_n) begin
      m_arm = 0; m_pd = 0; m_pwr = 0; m_map = 0; m_wake = 0; s1 = 1; s2 = 1;
      model_live = 1;
    end else begin
      wk  = m_pd && m_wake[7] &&
            ((!m_wake[4] && !(s2 && port_latch)) || (m_wake[4] && bus_active));
      act = !m_pd && sfr_wr;
      st  = act && insn_done && sfr_addr == A_PWR && sfr_wdata[6] && !sfr_wdata[1] && m_arm;
      armw = act && insn_done && sfr_addr == A_PWR && sfr_wdata[1] && !sfr_wdata[6];
      old_map = m_map;
      if (act) begin
        if (sfr_addr == A_PWR) m_pwr = sfr_wdata & 8'hBD;
        if (sfr_addr == A_MAP) m_map = sfr_wdata;
        if (sfr_addr == A_WAKE && old_map[4]) m_wake = sfr_wdata;
      end
      if (armw) m_arm = 1;
      else if (insn_done || act) m_arm = 0;
      if (m_pd && wk) m_pd = 0;
      else if (st) m_pd = 1;
      s2 = s1; s1 = wake_pin;
    end
  end

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a == A_PWR) return m_pwr;
    if (a == A_MAP) return m_map;
    if (a == A_WAKE && m_map[4]) return m_wake;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (model_live && !done) begin
    chk("R1 model clk_stop", {7'd0, clk_stop}, {7'd0, m_pd});
    chk("R3 model rd_data", rd_data, model_rd(rd_addr));
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1; insn_done = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 0; insn_done = 0;
  endtask

  task automatic insn_only();
    @(negedge clk); insn_done = 1;
    @(negedge clk); insn_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a; #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    idle(2); rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R11 reset state
    chk("R11 clk_stop after reset", {7'd0, clk_stop}, 8'd0);
    peek("R11 pwr reg", A_PWR, 8'h00);
    peek("R11 map reg", A_MAP, 8'h00);

    // R2 both bits at once
    wr(A_PWR, 8'h42);
    chk("R2 combined write", {7'd0, clk_stop}, 8'd0);
    wr(A_PWR, 8'h40); idle(1);
    chk("R2 start after combined", {7'd0, clk_stop}, 8'd0);

    // R4 intervening write, intervening instruction, lone start
    wr(A_PWR, 8'h02); wr(A_MAP, 8'h00); wr(A_PWR, 8'h40);
    chk("R4 write in between", {7'd0, clk_stop}, 8'd0);
    wr(A_PWR, 8'h02); insn_only(); wr(A_PWR, 8'h40);
    chk("R4 insn in between", {7'd0, clk_stop}, 8'd0);
    wr(A_PWR, 8'h40);
    chk("R4 lone start", {7'd0, clk_stop}, 8'd0);

    // R3 other bits readable, self-clearing bits hidden
    wr(A_PWR, 8'hFF);
    peek("R3 pwr readback", A_PWR, 8'hBD);
    wr(A_PWR, 8'h00);

    // R6 wake reg gated by map bit
    wr(A_WAKE, 8'h80);
    peek("R6 gated read", A_WAKE, 8'h00);
    wr(A_MAP, 8'h10);
    peek("R6 dropped write", A_WAKE, 8'h00);
    wr(A_MAP, 8'h00);

    // R1 + R5 enter with wake disabled
    wr(A_PWR, 8'h02); wr(A_PWR, 8'h40);
    chk("R1 entry", {7'd0, clk_stop}, 8'd1);
    wake_pin = 0; bus_active = 1; idle(6);
    chk("R5 no wake while disabled", {7'd0, clk_stop}, 8'd1);
    wake_pin = 1; bus_active = 0;
    do_reset(); idle(1);
    chk("R11 reset exits", {7'd0, clk_stop}, 8'd0);

    // R7 pin wake latency
    wr(A_MAP, 8'h10); wr(A_WAKE, 8'h80); wr(A_MAP, 8'h00);
    wr(A_PWR, 8'h02); wr(A_PWR, 8'h40);
    chk("R7 entered", {7'd0, clk_stop}, 8'd1);
    // R10 write during power-down ignored
    wr(A_MAP, 8'h10); wr(A_WAKE, 8'h00);
    chk("R10 still stopped", {7'd0, clk_stop}, 8'd1);
    wake_pin = 0; idle(2);
    chk("R7 still stopped at 2 edges", {7'd0, clk_stop}, 8'd1);
    idle(1);
    chk("R7 wake at 3rd edge", {7'd0, clk_stop}, 8'd0);
    wake_pin = 1;
    peek("R10 map unchanged", A_MAP, 8'h00);
    wr(A_MAP, 8'h10);
    peek("R10 wake unchanged", A_WAKE, 8'h80);
    wr(A_MAP, 8'h00);
    idle(3);

    // R8 latch 0 -> one-cycle power-down
    port_latch = 0;
    wr(A_PWR, 8'h02); wr(A_PWR, 8'h40);
    chk("R8 one cycle high", {7'd0, clk_stop}, 8'd1);
    idle(1);
    chk("R8 dropped next edge", {7'd0, clk_stop}, 8'd0);
    port_latch = 1;

    // R9 bus wake, pin ignored
    wr(A_MAP, 8'h10); wr(A_WAKE, 8'h90); wr(A_MAP, 8'h00);
    wr(A_PWR, 8'h02); wr(A_PWR, 8'h40);
    wake_pin = 0; idle(5);
    chk("R9 pin ignored", {7'd0, clk_stop}, 8'd1);
    bus_active = 1; idle(1);
    chk("R9 bus wake", {7'd0, clk_stop}, 8'd0);
    bus_active = 0; wake_pin = 1; idle(3);

    finish_run();
  end
endmodule